// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block is the clock-policy state machine of a microcontroller. It holds the current operating mode and turns it into enables for the main oscillator, the sub oscillator, the PLL, the CPU clock, the peripheral clock, the timebase timer and the watch timer. It also drives a code that picks the machine clock source. Software moves the block between modes by writing a mode code. A wake-up interrupt brings each sleep, watch, pseudo-watch or stop state back to the run mode that belongs to it.

Leaving main stop passes through a stabilization state. That state holds the CPU clock off for a programmable number of cycles while the main oscillator restarts. The block also latches a PLL multiply factor, but only while the PLL is off. An optional intermittent mode thins the CPU clock to one cycle in `INT_DIV` during CPU accesses, and the peripheral clock keeps full speed.

The states, with the code shown on `mode_state`, are:

| Code | State | Meaning |
|------|-------|---------|
| 0 | PLL_RUN | runs from the PLL |
| 1 | PLL_SLEEP | CPU clock off |
| 2 | PLL_WATCH | watch timer only |
| 3 | PSEUDO | watch timer and timebase timer |
| 4 | MAIN_RUN | runs from main/2 |
| 5 | MAIN_SLEEP | CPU clock off |
| 6 | MAIN_WATCH | watch timer only |
| 7 | MAIN_STOP | all oscillators off |
| 8 | SUB_RUN | runs from the sub clock |
| 9 | SUB_SLEEP | CPU clock off |
| 10 | SUB_WATCH | watch timer only |
| 11 | SUB_STOP | all oscillators off |
| 12 | STAB | main oscillator settling |

The transitions are:
- **switch**: a run state moves to any run state.
- **enter**: a run state moves to one of its own low-power states. PSEUDO is entered from PLL_RUN.
- **wake**: a low-power state returns to its own run state. PSEUDO returns to PLL_RUN. MAIN_STOP goes to STAB.
- **settle**: STAB moves to MAIN_RUN when its count ends.
- **reject**: an illegal request leaves the state unchanged and flags an error.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: After reset the state is MAIN_RUN (code 4), `pll_en` is 0, `pll_mult` is 2, `req_err` is 0 and `clk_src` is 0.
- R2: In a run state (code 0, 4 or 8), `req_valid` with `req_mode` equal to 0, 4 or 8 is accepted. The family's own low-power codes are also accepted: 1, 2 and 3 from code 0, 5, 6 and 7 from code 4, and 9, 10 and 11 from code 8. An accepted request shows on `mode_state` one cycle later.
- R3: Any other request is ignored: the state does not change and `req_err` is high for exactly the following cycle. This covers codes 12 to 15, another family's low-power code, and any request made outside a run state.
- R4: Clock sources are coded on `clk_src` as 0 for main/2, 1 for PLL and 2 for sub. The enable outputs per state are as follows.
  - PLL_RUN: all seven enables are on, and `clk_src` is 1.
  - MAIN_RUN: everything except the PLL is on, and `clk_src` is 0.
  - SUB_RUN: the sub oscillator, CPU, peripheral and watch timer are on, and `clk_src` is 2.
  - Each sleep state is its run state with only `cpu_clk_en` cleared.
- R5: In every watch state (codes 2, 6 and 10), only `sub_osc_en` and `wt_clk_en` are high, and `clk_src` is 2.
- R6: In PSEUDO (code 3), only `main_osc_en`, `sub_osc_en`, `tbt_clk_en` and `wt_clk_en` are high.
- R7: In MAIN_STOP and SUB_STOP, all seven enables are low.
- R8: `wake_irq` takes codes 1, 2 and 3 to 0, codes 5 and 6 to 4, and codes 9, 10 and 11 to 8, one cycle later. In a run state it has no effect.
- R9: `wake_irq` in MAIN_STOP enters STAB (code 12), and `stab_busy` follows STAB. STAB lasts exactly 2^10, 2^13, 2^15 or 2^17 cycles for `wait_sel` = 0, 1, 2 or 3, sampled at the wake. In STAB only `main_osc_en` and `sub_osc_en` are on, and `cpu_clk_en` stays low. The state then becomes MAIN_RUN.
- R10: `pll_mult` takes the value 2·(`mul_sel`+1) on every clock edge at which `pll_en` is low. While the PLL runs, changes of `mul_sel` are ignored.
- R11: In a run state with `intermit_en` and `cpu_access` both high, `cpu_clk_en` is high on exactly one cycle in every `INT_DIV` cycles (default 4), and `per_clk_en` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | mode request strobe |
| req_mode | input | 4 | requested state code |
| wake_irq | input | 1 | wake-up interrupt |
| mul_sel | input | 2 | PLL multiply select |
| wait_sel | input | 2 | stabilization length select |
| intermit_en | input | 1 | enables intermittent CPU clock |
| cpu_access | input | 1 | CPU is making a bus or resource access |
| main_osc_en | output | 1 | main oscillator enable |
| sub_osc_en | output | 1 | sub oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | peripheral clock enable |
| tbt_clk_en | output | 1 | timebase timer clock enable |
| wt_clk_en | output | 1 | watch timer clock enable |
| clk_src | output | 2 | machine clock source code |
| pll_mult | output | 4 | latched PLL multiply factor |
| mode_state | output | 4 | current state code |
| req_err | output | 1 | one-cycle illegal request flag |
| stab_busy | output | 1 | stabilization in progress |

## Verification
Random requests and wakes are compared every cycle against a bench model. The bench goes after cross-family requests such as main stop asked from PLL run. A design that accepts them would park the chip with no path back to its run mode. Wakes in run states are exercised, where a sloppy design would jump to another mode. The STAB length is measured exactly for one `wait_sel`, where an off-by-one count would release the CPU a cycle early or late. `mul_sel` is changed while the PLL runs, which catches a factor that changes under a locked PLL. The intermittent ratio is counted over a window, where a wrong divider shows as too many or too few CPU clock pulses.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [3:0] {
        M_PLL_RUN    = 4'd0,
        M_PLL_SLEEP  = 4'd1,
        M_PLL_WATCH  = 4'd2,
        M_PSEUDO     = 4'd3,
        M_MAIN_RUN   = 4'd4,
        M_MAIN_SLEEP = 4'd5,
        M_MAIN_WATCH = 4'd6,
        M_MAIN_STOP  = 4'd7,
        M_SUB_RUN    = 4'd8,
        M_SUB_SLEEP  = 4'd9,
        M_SUB_WATCH  = 4'd10,
        M_SUB_STOP   = 4'd11,
        M_STAB       = 4'd12
    } mode_e;

    localparam logic [1:0] SRC_MAIN = 2'd0;
    localparam logic [1:0] SRC_PLL  = 2'd1;
    localparam logic [1:0] SRC_SUB  = 2'd2;

    typedef struct packed {
        logic       main_osc;
        logic       sub_osc;
        logic       pll;
        logic       cpu;
        logic       per;
        logic       tbt;
        logic       wt;
        logic [1:0] src;
    } clk_en_t;
endpackage

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int EXP0 = 10,
    parameter int EXP1 = 13,
    parameter int EXP2 = 15,
    parameter int EXP3 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic [1:0] wait_sel,
    output logic       done
);
    localparam int CW = EXP3 + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    function automatic logic [CW-1:0] limit_of(input logic [1:0] sel);
        logic [CW-1:0] one;
        one = '0;
        one[0] = 1'b1;
        case (sel)
            2'd0:    return one << EXP0;
            2'd1:    return one << EXP1;
            2'd2:    return one << EXP2;
            default: return one << EXP3;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= limit_of(wait_sel);
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == lim - 1'b1);

    // R9: count never runs past the latched limit
    assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < lim));
endmodule

// File: rtl/lpm_cpu_gate.sv
module lpm_cpu_gate #(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_mode,
    input  logic cpu_want,
    input  logic intermit_en,
    input  logic cpu_access,
    output logic cpu_clk_en
);
    localparam int DW = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(INT_DIV - 1);

    logic [DW-1:0] phase;
    logic          thin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    assign thin       = run_mode && intermit_en && cpu_access;
    assign cpu_clk_en = cpu_want && (!thin || (phase == '0));

    // R11: a thinned pulse is never followed by another while thinning holds
    assert_thin_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (thin && cpu_clk_en) |=> (!thin || !cpu_clk_en));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [3:0] req_mode,
    input  logic       wake_irq,
    input  logic       stab_done,
    output mode_e      state,
    output clk_en_t    en,
    output logic       req_err,
    output logic       stab_start,
    output logic       run_mode
);
    mode_e nxt;
    logic  err_nxt;

    function automatic logic legal(input mode_e cur, input logic [3:0] tgt);
        if (tgt == 4'd0 || tgt == 4'd4 || tgt == 4'd8) return 1'b1;
        case (cur)
            M_PLL_RUN:  return (tgt >= 4'd1) && (tgt <= 4'd3);
            M_MAIN_RUN: return (tgt >= 4'd5) && (tgt <= 4'd7);
            M_SUB_RUN:  return (tgt >= 4'd9) && (tgt <= 4'd11);
            default:    return 1'b0;
        endcase
    endfunction

    assign run_mode = (state == M_PLL_RUN) || (state == M_MAIN_RUN) || (state == M_SUB_RUN);

    always_comb begin
        nxt     = state;
        err_nxt = 1'b0;
        unique case (state)
            M_PLL_RUN, M_MAIN_RUN, M_SUB_RUN: begin
                if (req_valid) begin
                    if (legal(state, req_mode)) nxt = mode_e'(req_mode);
                    else                        err_nxt = 1'b1;
                end
            end
            M_PLL_SLEEP, M_PLL_WATCH, M_PSEUDO: begin
                err_nxt = req_valid;
                if (wake_irq) nxt = M_PLL_RUN;
            end
            M_MAIN_SLEEP, M_MAIN_WATCH: begin
                err_nxt = req_valid;
                if (wake_irq) nxt = M_MAIN_RUN;
            end
            M_MAIN_STOP: begin
                err_nxt = req_valid;
                if (wake_irq) nxt = M_STAB;
            end
            M_SUB_SLEEP, M_SUB_WATCH, M_SUB_STOP: begin
                err_nxt = req_valid;
                if (wake_irq) nxt = M_SUB_RUN;
            end
            M_STAB: begin
                err_nxt = req_valid;
                if (stab_done) nxt = M_MAIN_RUN;
            end
            default: nxt = M_MAIN_RUN;
        endcase
    end

    assign stab_start = (state == M_MAIN_STOP) && wake_irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= M_MAIN_RUN;
            req_err <= 1'b0;
        end else begin
            state   <= nxt;
            req_err <= err_nxt;
        end
    end

    always_comb begin
        en = '0;
        unique case (state)
            M_PLL_RUN:    en = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, SRC_PLL};
            M_PLL_SLEEP:  en = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, SRC_PLL};
            M_PSEUDO:     en = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_MAIN};
            M_MAIN_RUN:   en = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, SRC_MAIN};
            M_MAIN_SLEEP: en = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_MAIN};
            M_PLL_WATCH, M_MAIN_WATCH, M_SUB_WATCH:
                          en = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SRC_SUB};
            M_MAIN_STOP:  en = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SRC_MAIN};
            M_SUB_RUN:    en = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, SRC_SUB};
            M_SUB_SLEEP:  en = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, SRC_SUB};
            M_SUB_STOP:   en = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SRC_SUB};
            M_STAB:       en = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SRC_MAIN};
            default:      en = '0;
        endcase
    end

    // R3: the error flag only follows a request
    assert_err_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid));
    // R8: main watch returns to main run
    assert_watch_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_MAIN_WATCH && wake_irq) |=> (state == M_MAIN_RUN));
    // R9: main stop wake goes through stabilization
    assert_stop_to_stab_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_MAIN_STOP && wake_irq) |=> (state == M_STAB));
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int INT_DIV = 4,
    parameter int EXP0    = 10,
    parameter int EXP1    = 13,
    parameter int EXP2    = 15,
    parameter int EXP3    = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [3:0] req_mode,
    input  logic       wake_irq,
    input  logic [1:0] mul_sel,
    input  logic [1:0] wait_sel,
    input  logic       intermit_en,
    input  logic       cpu_access,
    output logic       main_osc_en,
    output logic       sub_osc_en,
    output logic       pll_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       tbt_clk_en,
    output logic       wt_clk_en,
    output logic [1:0] clk_src,
    output logic [3:0] pll_mult,
    output logic [3:0] mode_state,
    output logic       req_err,
    output logic       stab_busy
);
    mode_e   state;
    clk_en_t en;
    logic    stab_start;
    logic    stab_done;
    logic    run_mode;

    lpm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .wake_irq   (wake_irq),
        .stab_done  (stab_done),
        .state      (state),
        .en         (en),
        .req_err    (req_err),
        .stab_start (stab_start),
        .run_mode   (run_mode)
    );

    lpm_stab_timer #(.EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)) u_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (stab_start),
        .active   (state == M_STAB),
        .wait_sel (wait_sel),
        .done     (stab_done)
    );

    lpm_cpu_gate #(.INT_DIV(INT_DIV)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_mode    (run_mode),
        .cpu_want    (en.cpu),
        .intermit_en (intermit_en),
        .cpu_access  (cpu_access),
        .cpu_clk_en  (cpu_clk_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pll_mult <= 4'd2;
        else if (!en.pll) pll_mult <= {1'b0, mul_sel, 1'b0} + 4'd2;
    end

    assign main_osc_en = en.main_osc;
    assign sub_osc_en  = en.sub_osc;
    assign pll_en      = en.pll;
    assign per_clk_en  = en.per;
    assign tbt_clk_en  = en.tbt;
    assign wt_clk_en   = en.wt;
    assign clk_src     = en.src;
    assign mode_state  = state;
    assign stab_busy   = (state == M_STAB);

    // R9: CPU held off through stabilization
    assert_stab_cpu_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> !cpu_clk_en);
    // R10: multiplier frozen while the PLL runs
    assert_mult_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en && $past(pll_en)) |-> $stable(pll_mult));
    // R7: stop states leave everything dark
    assert_stop_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == 4'd7 || mode_state == 4'd11) |-> (!main_osc_en && !sub_osc_en && !cpu_clk_en));
endmodule

// File: tb/lpm_clock_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_clock_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_mode = 4'd0;
    logic       wake_irq = 1'b0;
    logic [1:0] mul_sel = 2'd0;
    logic [1:0] wait_sel = 2'd0;
    logic       intermit_en = 1'b0;
    logic       cpu_access = 1'b0;
    logic       main_osc_en, sub_osc_en, pll_en, cpu_clk_en, per_clk_en, tbt_clk_en, wt_clk_en;
    logic [1:0] clk_src;
    logic [3:0] pll_mult, mode_state;
    logic       req_err, stab_busy;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    lpm_clock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .wake_irq(wake_irq), .mul_sel(mul_sel), .wait_sel(wait_sel),
        .intermit_en(intermit_en), .cpu_access(cpu_access),
        .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .pll_en(pll_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .tbt_clk_en(tbt_clk_en),
        .wt_clk_en(wt_clk_en), .clk_src(clk_src), .pll_mult(pll_mult),
        .mode_state(mode_state), .req_err(req_err), .stab_busy(stab_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {main, sub, pll, cpu, per, tbt, wt, src[1:0]} per state code
    function automatic logic [8:0] en_of(input int m);
        case (m)
            0:          return 9'b1111111_01;
            1:          return 9'b1110111_01;
            2, 6, 10:   return 9'b0100001_10;
            3:          return 9'b1100011_00;
            4:          return 9'b1101111_00;
            5:          return 9'b1100111_00;
            7:          return 9'b0000000_00;
            8:          return 9'b0101101_10;
            9:          return 9'b0100101_10;
            11:         return 9'b0000000_10;
            default:    return 9'b1100000_00;
        endcase
    endfunction

    function automatic bit accepts(input int cur, input int tgt);
        if (tgt > 11) return 0;
        if (tgt % 4 == 0) return 1;
        if (cur == 0) return (tgt >= 1 && tgt <= 3);
        if (cur == 4 || cur == 8) return (tgt / 4 == cur / 4);
        return 0;
    endfunction

    function automatic int wake_to(input int cur);
        if (cur >= 1 && cur <= 3) return 0;
        if (cur == 5 || cur == 6) return 4;
        if (cur == 7) return 12;
        if (cur >= 9 && cur <= 11) return 8;
        return cur;
    endfunction

    function automatic int lim_of(input int sel);
        case (sel)
            0: return 1 << 10;
            1: return 1 << 13;
            2: return 1 << 15;
            default: return 1 << 17;
        endcase
    endfunction

    function automatic logic [8:0] dut_en();
        return {main_osc_en, sub_osc_en, pll_en, cpu_clk_en, per_clk_en, tbt_clk_en, wt_clk_en, clk_src};
    endfunction

    task automatic request(input int code);
        req_valid = 1'b1; req_mode = 4'(code);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wake();
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int m, mcnt, mlim, pm, nm;
        logic em;
        int hits, pers;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 state", mode_state, 4);
        check("R1 pll_en", pll_en, 0);
        check("R1 pll_mult", pll_mult, 2);
        check("R1 req_err", req_err, 0);
        check("R1 clk_src", clk_src, 0);

        // R3 cross-family and out-of-range requests
        request(1);
        check("R3 state kept", mode_state, 4);
        check("R3 err pulse", req_err, 1);
        @(negedge clk);
        check("R3 err one cycle", req_err, 0);
        request(13);
        check("R3 code13 kept", mode_state, 4);
        check("R3 code13 err", req_err, 1);

        // R8 wake in run ignored
        wake();
        check("R8 wake in run", mode_state, 4);

        // R9 measured stabilization, wait_sel=1
        request(7);
        check("R7 main stop", mode_state, 7);
        check("R7 stop enables", dut_en(), en_of(7));
        wait_sel = 2'd1;
        wake();
        wait_sel = 2'd3;
        hits = 0;
        while (stab_busy && hits < 20000) begin
            if (cpu_clk_en) check("R9 cpu off in stab", cpu_clk_en, 0);
            hits++;
            @(negedge clk);
        end
        check("R9 stab length", hits, 8192);
        check("R9 back to main run", mode_state, 4);
        wait_sel = 2'd0;

        // R10 multiplier frozen while PLL runs
        mul_sel = 2'd2;
        @(negedge clk);
        check("R10 latch while off", pll_mult, 6);
        request(0);
        check("R10 clk_src pll", clk_src, 1);
        mul_sel = 2'd3;
        repeat (3) @(negedge clk);
        check("R10 frozen", pll_mult, 6);

        // R11 intermittent CPU clock
        intermit_en = 1'b1; cpu_access = 1'b1;
        hits = 0; pers = 0;
        for (int i = 0; i < 40; i++) begin
            hits += cpu_clk_en; pers += per_clk_en;
            @(negedge clk);
        end
        check("R11 thinned count", hits, 10);
        check("R11 peripheral full", pers, 40);
        cpu_access = 1'b0;
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            hits += cpu_clk_en;
            @(negedge clk);
        end
        check("R11 no access full", hits, 40);
        intermit_en = 1'b0;

        // R6 pseudo-watch and return
        request(3);
        check("R6 pseudo enables", dut_en(), en_of(3));
        wake();
        check("R8 pseudo to pll", mode_state, 0);

        // Random phase: R2 R3 R4 R5 R6 R7 R8 against model
        m = mode_state; mcnt = 0; mlim = 0; pm = pll_mult; em = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            check("R2 state", mode_state, m);
            check("R4 R5 R6 enables", dut_en(), en_of(m));
            check("R3 err", req_err, em);
            check("R10 mult", pll_mult, pm);
            req_valid = ($urandom % 3) == 0;
            req_mode  = 4'($urandom % 16);
            wake_irq  = ($urandom % 8) == 0;
            mul_sel   = 2'($urandom % 4);
            if (!en_of(m)[6]) pm = 2 * (int'(mul_sel) + 1);
            em = 1'b0; nm = m;
            if (m == 0 || m == 4 || m == 8) begin
                if (req_valid) begin
                    if (accepts(m, req_mode)) nm = req_mode;
                    else em = 1'b1;
                end
            end else begin
                em = req_valid;
                if (m == 12) begin
                    if (mcnt == mlim - 1) nm = 4; else mcnt++;
                end else if (wake_irq) begin
                    nm = wake_to(m);
                    if (nm == 12) begin mcnt = 0; mlim = lim_of(wait_sel); end
                end
            end
            m = nm;
            @(negedge clk);
        end
        req_valid = 1'b0; wake_irq = 1'b0;

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule